// File: doc/BRIEF.md
# Glitch-free two-input clock selector

This block chooses which of two free-running, mutually asynchronous clocks drives a single clock output. A level select input names the wanted clock. When the select changes, the block releases the old clock only when that clock sits at an idle level. It holds the output at that idle level, then admits the new clock only when the new clock itself arrives at the idle level. Because of this, the output never carries a runt pulse or a glitch.

A build-time parameter picks the idle (parking) level. With a Low parking level, the enable logic runs on falling clock edges. With a High parking level, it runs on rising edges. The select is brought into each clock domain through its own chain of flops. Each domain's enable may only turn on once the other domain's whole chain is seen empty. The two enables therefore never overlap, even when the select is reversed while a switch is still in progress.

Top module: `clkmux_glitchfree`

## Requirements
- R1: While the active-low asynchronous reset is asserted, and after it is released with the select Low, the output follows clock A and clock B is not passed, whatever the select did during reset.
- R2: Select Low (0) chooses clock A and select High (1) chooses clock B. Once the select has been steady for a few periods of both clocks, the output equals the chosen clock at every mid-phase sample.
- R3: With Low parking, a switch holds the output Low from the moment the old clock is released. The new clock is admitted at one of its own falling edges, so the first output transition after the hold is a rising edge of the new clock.
- R4: With High parking, a switch holds the output High from the moment the old clock is released. The new clock is admitted at one of its own rising edges, so the first output transition after the hold is a falling edge of the new clock.
- R5: The two per-clock enables are never high together. An enable turns on only while the other clock's enable is off.
- R6: Every High and every Low phase of the output lasts at least as long as the shorter half-period of the two input clocks.
- R7: If the newly chosen clock is stopped, the output stays at the parking level for as long as it is stopped and never returns to the old clock. Once the clock restarts, the output follows it.
- R8: If the select is reversed before a switch completes, the switching settles with exactly one clock passed: the one the select finally names.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | First free-running clock, chosen when the select is Low |
| clk_b_i | input | 1 | Second free-running clock, chosen when the select is High |
| pick_b_i | input | 1 | Clock select: 0 picks clock A, 1 picks clock B |
| arst_ni | input | 1 | Asynchronous reset, active Low |
| clk_o | output | 1 | Selected clock, parked at the idle level during a switch |

## Verification
Two things can coincide: a handover still in progress, and a fresh reversal of the select. While one clock's chain is emptying, the other may be starting to fill. The bench provokes this by flipping the select back after delays shorter than one synchronizer pass, and by toggling it at random instants against two clocks whose edges never coincide. Each such case is judged three ways: every output phase is timed against the shortest half-period, the enables are checked for overlap at every edge, and after settling the output is compared at mid-phase points against the clock the final select names.

// File: rtl/clkmux_pkg.sv
`timescale 1ns/1ps
package clkmux_pkg;
  // Idle level the output rests at while the selection is handed over.
  typedef enum logic {
    PARK_LOW  = 1'b0,
    PARK_HIGH = 1'b1
  } park_e;
endpackage

// File: rtl/clkmux_leg.sv
`timescale 1ns/1ps
// One clock domain's enable path: a flop chain that carries "this clock is
// wanted and the other domain is idle" towards the output gate.
module clkmux_leg
  import clkmux_pkg::*;
#(
  parameter park_e PARK      = PARK_LOW,
  parameter int    STAGES    = 2,
  parameter bit    RESET_ON  = 1'b0
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic want_i,
  input  logic other_busy_i,
  output logic en_o,
  output logic busy_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          load_d;

  // Enable only while the opposite chain is entirely empty.
  assign load_d = want_i & ~other_busy_i;

  generate
    if (PARK == PARK_HIGH) begin : g_rise
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q <= {STAGES{RESET_ON}};
        else          chain_q <= {chain_q[LAST-1:0], load_d};
      end
    end else begin : g_fall
      always_ff @(negedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q <= {STAGES{RESET_ON}};
        else          chain_q <= {chain_q[LAST-1:0], load_d};
      end
    end
  endgenerate

  assign en_o   = chain_q[LAST];
  assign busy_o = |chain_q;
endmodule

// File: rtl/clkmux_gate.sv
`timescale 1ns/1ps
// Output combiner: passes each enabled clock, forces the parking level
// when neither is enabled.
module clkmux_gate
  import clkmux_pkg::*;
#(
  parameter park_e PARK = PARK_LOW
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic en_a_i,
  input  logic en_b_i,
  output logic clk_o
);
  generate
    if (PARK == PARK_HIGH) begin : g_and
      assign clk_o = (clk_a_i | ~en_a_i) & (clk_b_i | ~en_b_i);
    end else begin : g_or
      assign clk_o = (clk_a_i & en_a_i) | (clk_b_i & en_b_i);
    end
  endgenerate
endmodule

// File: rtl/clkmux_glitchfree.sv
`timescale 1ns/1ps
module clkmux_glitchfree
  import clkmux_pkg::*;
#(
  parameter park_e PARK        = PARK_LOW,
  parameter int    SYNC_STAGES = 2
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic pick_b_i,
  input  logic arst_ni,
  output logic clk_o
);
  logic en_a, en_b;
  logic busy_a, busy_b;

  // Domain A comes out of reset owning the output.
  clkmux_leg #(.PARK(PARK), .STAGES(SYNC_STAGES), .RESET_ON(1'b1)) i_leg_a (
    .clk_i        (clk_a_i),
    .arst_ni      (arst_ni),
    .want_i       (~pick_b_i),
    .other_busy_i (busy_b),
    .en_o         (en_a),
    .busy_o       (busy_a)
  );

  clkmux_leg #(.PARK(PARK), .STAGES(SYNC_STAGES), .RESET_ON(1'b0)) i_leg_b (
    .clk_i        (clk_b_i),
    .arst_ni      (arst_ni),
    .want_i       (pick_b_i),
    .other_busy_i (busy_a),
    .en_o         (en_b),
    .busy_o       (busy_b)
  );

  clkmux_gate #(.PARK(PARK)) i_gate (
    .clk_a_i (clk_a_i),
    .clk_b_i (clk_b_i),
    .en_a_i  (en_a),
    .en_b_i  (en_b),
    .clk_o   (clk_o)
  );
endmodule

// File: rtl/clkmux_glitchfree_chk.sv
`timescale 1ns/1ps
module clkmux_glitchfree_chk
  import clkmux_pkg::*;
#(
  parameter park_e PARK = PARK_LOW
) (
  input logic clk_a,
  input logic clk_b,
  input logic arst_n,
  input logic en_a,
  input logic en_b,
  input logic clk_out
);
  // R5: enables never overlap, seen from either domain
  a_r5_mutex_on_a: assert property (@(posedge clk_a) disable iff (!arst_n)
    !(en_a && en_b));
  a_r5_mutex_on_b: assert property (@(posedge clk_b) disable iff (!arst_n)
    !(en_a && en_b));
  // R5: an enable rises only while the other one is off
  a_r5_handoff_b: assert property (@(posedge clk_b) disable iff (!arst_n)
    $rose(en_b) |-> !en_a);
  a_r5_handoff_a: assert property (@(posedge clk_a) disable iff (!arst_n)
    $rose(en_a) |-> !en_b);
  // R3 / R4: with both enables off the output rests at the parking level
  a_r3_r4_parked: assert property (@(posedge clk_a) disable iff (!arst_n)
    (!en_a && !en_b) |-> (clk_out == logic'(PARK)));
endmodule

bind clkmux_glitchfree clkmux_glitchfree_chk #(.PARK(PARK)) i_chk (
  .clk_a   (clk_a_i),
  .clk_b   (clk_b_i),
  .arst_n  (arst_ni),
  .en_a    (en_a),
  .en_b    (en_b),
  .clk_out (clk_o)
);

// File: tb/test_clkmux_glitchfree.sv
`timescale 1ns/1ps
module test_clkmux_glitchfree;
  import clkmux_pkg::*;

  localparam real CLK_PERIOD = 10.0;
  localparam real HALF_A     = CLK_PERIOD / 2.0;
  localparam real HALF_B     = 7.3;
  localparam real MIN_PHASE  = (HALF_A < HALF_B) ? HALF_A : HALF_B;
  localparam real SETTLE     = 120.0;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic run_b = 1'b1;
  logic pick_b = 1'b0;
  logic arst_n = 1'b1;
  logic out_lo, out_hi;
  logic mon = 1'b0;

  int checks = 0;
  int failures = 0;

  clkmux_glitchfree #(.PARK(PARK_LOW)) i_clkmux_glitchfree (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .pick_b_i(pick_b),
    .arst_ni(arst_n), .clk_o(out_lo));

  clkmux_glitchfree #(.PARK(PARK_HIGH)) i_clkmux_glitchfree_hi (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .pick_b_i(pick_b),
    .arst_ni(arst_n), .clk_o(out_hi));

  // Clocks: B starts with an offset so no edge of B meets an edge of A.
  initial forever #(HALF_A) clk_a = ~clk_a;
  initial begin
    #0.35;
    forever begin
      #(HALF_B);
      if (run_b) clk_b = ~clk_b;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: in a settled state both outputs equal the
  // chosen clock; sample a quarter period into each phase.
  task automatic check_follow(input bit use_b, input string tag);
    for (int k = 0; k < 4; k++) begin
      if (use_b) begin
        @(posedge clk_b); #(HALF_B / 2.0);
        chk({tag, " lo high"}, out_lo, clk_b);
        chk({tag, " hi high"}, out_hi, clk_b);
        @(negedge clk_b); #(HALF_B / 2.0);
        chk({tag, " lo low"}, out_lo, clk_b);
        chk({tag, " hi low"}, out_hi, clk_b);
      end else begin
        @(posedge clk_a); #(HALF_A / 2.0);
        chk({tag, " lo high"}, out_lo, clk_a);
        chk({tag, " hi high"}, out_hi, clk_a);
        @(negedge clk_a); #(HALF_A / 2.0);
        chk({tag, " lo low"}, out_lo, clk_a);
        chk({tag, " hi low"}, out_hi, clk_a);
      end
    end
  endtask

  // R6: phase width monitors
  realtime last_lo = 0.0, last_hi = 0.0;
  bit have_lo = 1'b0, have_hi = 1'b0;
  always @(out_lo) begin
    if (mon) begin
      if (have_lo) begin
        checks++;
        if ($realtime - last_lo < MIN_PHASE - 0.001) begin
          failures++;
          $display("FAIL R6 low-park phase actual=%0.3f expected>=%0.3f at %0t",
                   $realtime - last_lo, MIN_PHASE, $time);
        end
      end
      last_lo = $realtime;
      have_lo = 1'b1;
    end
  end
  always @(out_hi) begin
    if (mon) begin
      if (have_hi) begin
        checks++;
        if ($realtime - last_hi < MIN_PHASE - 0.001) begin
          failures++;
          $display("FAIL R6 high-park phase actual=%0.3f expected>=%0.3f at %0t",
                   $realtime - last_hi, MIN_PHASE, $time);
        end
      end
      last_hi = $realtime;
      have_hi = 1'b1;
    end
  end

  // R3 / R4: first output edge after the parked stretch
  task automatic check_first_edge_after_restart();
    logic lo_seen, hi_seen;
    lo_seen = 1'b0; hi_seen = 1'b0;
    run_b = 1'b1;
    fork
      begin
        @(out_lo);
        chk("R3 first edge is rising", out_lo, 1'b1);
        chk("R3 rising coincides with new clock", clk_b, 1'b1);
      end
      begin
        @(out_hi);
        chk("R4 first edge is falling", out_hi, 1'b0);
        chk("R4 falling coincides with new clock", clk_b, 1'b0);
      end
    join
  endtask

  initial begin
    #1 arst_n = 1'b0;
    // R1: during reset, select ignored, clock A passed
    pick_b = 1'b1;
    #30;
    check_follow(1'b0, "R1 in reset");
    pick_b = 1'b0;
    #3 arst_n = 1'b1;
    mon = 1'b1;
    check_follow(1'b0, "R1 after reset");

    // R2: plain switch to B and back
    pick_b = 1'b1; #(SETTLE);
    check_follow(1'b1, "R2 select B (R5 no overlap)");
    pick_b = 1'b0; #(SETTLE);
    check_follow(1'b0, "R2 select A (R5 no overlap)");

    // R7: switch to a stopped clock
    @(negedge clk_b); run_b = 1'b0;
    pick_b = 1'b1; #(SETTLE);
    for (int k = 0; k < 10; k++) begin
      #13.7;
      chk("R3 R7 low park held", out_lo, 1'b0);
      chk("R4 R7 high park held", out_hi, 1'b1);
    end
    check_first_edge_after_restart();
    #(SETTLE);
    check_follow(1'b1, "R7 follows after restart");

    // R8: reversal before the handover completes
    pick_b = 1'b0; #8.0; pick_b = 1'b1; #(SETTLE);
    check_follow(1'b1, "R8 reverse to B");
    pick_b = 1'b0; #25.0; pick_b = 1'b1; #3.0; pick_b = 1'b0; #(SETTLE);
    check_follow(1'b0, "R8 reverse to A");
    pick_b = 1'b1; #17.0; pick_b = 1'b0; #(SETTLE);
    check_follow(1'b0, "R8 late reverse to A");

    // R6 / R5: random toggling
    for (int k = 0; k < 60; k++) begin
      #($urandom_range(3, 70) * 1.0 + 0.13);
      pick_b = ~pick_b;
    end
    #(SETTLE);
    check_follow(pick_b, "R2 R8 after random toggles");

    mon = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000.0);
    failures++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule